// File: doc/BRIEF.md
# Digit-Serial Decimal Add/Subtract Unit

This unit adds or subtracts two multi-digit packed-decimal numbers, A and B, using a single one-digit decimal adder that is reused on every clock. Both operands are loaded in parallel into shift registers. A start pulse then launches a run of one digit per clock, from the least significant digit to the most significant. On each step the current A digit can pass through a nines-complement stage, and is then added to the current B digit together with a stored carry. The sum digit is shifted into the result register, and the carry out of the step is kept in a flip-flop for the next digit.

For subtraction, the carry flip-flop is preset to 1 when the run starts, so the unit computes B + (nines complement of A) + 1. This is the tens complement of A added to B, and gives B minus A. The final carry out then shows whether B was at least A. For addition the carry starts at 0, and the final carry marks a decimal overflow. The unit is used as a small arithmetic engine: load the operands, pulse start with the operation selected, wait for the one-cycle done pulse, then read the result and the final carry.

The controller has two states. ST_IDLE accepts loads and starts. The transition ST_IDLE to ST_RUN happens on a start and presets the carry. In ST_RUN the unit performs one digit step per clock and stays in ST_RUN until the last digit index. The transition ST_RUN to ST_IDLE happens on the last digit step, and at that point done is raised for the following cycle.

Top module: `bcd_serial_addsub`

## Requirements
- R1: After a synchronous reset, result_o is all zeros, carry_o is 0 and done_o is 0, and the controller is in ST_IDLE.
- R2: A load pulse in ST_IDLE captures a_i and b_i as the operands of the next run. Each 4-bit field of a_i and b_i is one decimal digit 0..9, with the least significant digit in bits [3:0].
- R3: With sub_i = 0 at start, result_o becomes (A + B) mod 10^DIGITS in the same digit packing, and carry_o is 1 exactly when A + B >= 10^DIGITS.
- R4: With sub_i = 1 at start, result_o becomes (B - A) mod 10^DIGITS, which is the tens-complement form when B < A, and carry_o is 1 exactly when B >= A.
- R5: If start is sampled at clock edge k, done_o is high for exactly the one cycle after edge k + DIGITS, and is low at all other times.
- R6: While in ST_IDLE, result_o and carry_o hold their values, regardless of load_i, sub_i or the operand inputs, until digit steps of a new run begin.
- R7: A start pulse received in ST_RUN is ignored. The current run keeps its operation and its done timing, and no second run follows.
- R8: A load pulse received in ST_RUN is ignored. The operand registers are emptied to zero by a run, so a later start without a new load computes with A = B = 0.
- R9: A synchronous reset during a run aborts it. The outputs clear as in R1 and no done pulse follows.
- R10: The carry flip-flop is preset to the value of sub_i when a start is accepted. As a result, A - A gives zero with carry 1, and B - 0 gives B with carry 1.
- R11: A carry produced in any digit step is passed on to the next digit, so a carry can ripple through every digit (for example 999 + 1 gives 000 with carry 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Parallel load of both operands (honoured in ST_IDLE only) |
| a_i | input | 4*DIGITS | Operand A, packed decimal digits, least significant digit in [3:0] |
| b_i | input | 4*DIGITS | Operand B, packed decimal digits, least significant digit in [3:0] |
| start_i | input | 1 | Starts a run (honoured in ST_IDLE only) |
| sub_i | input | 1 | Operation select, sampled at start: 0 = B plus A, 1 = B minus A |
| done_o | output | 1 | One-cycle pulse after the last digit step |
| result_o | output | 4*DIGITS | Result digits, packed like the operands |
| carry_o | output | 1 | Final decimal carry of the last run |

## Verification
On every cycle, the bound checker checks that done is a single-cycle pulse. It also checks that done arrives exactly DIGITS steps after an accepted start, measured with its own counter that ignores starts received while busy. Further cycle checks cover the carry preset on start, the holding of the result and final carry throughout ST_IDLE, and that every completed result digit is a valid decimal digit. The arithmetic itself can only be shown by the bench's scenarios: decimal sums and tens-complement differences over a broad sweep of operand pairs, digit-uniform patterns and full carry ripples. The same holds for the effects of ignored loads and starts, and of a reset in the middle of a run, which the bench observes at the outputs.

// File: rtl/bcd_serial_pkg.sv
package bcd_serial_pkg;

    localparam int DIGIT_W = 4;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

endpackage

// File: rtl/bcd_nines_comp.sv
module bcd_nines_comp
    import bcd_serial_pkg::*;
(
    input  logic [DIGIT_W-1:0] digit_i,
    input  logic               invert_i,
    output logic [DIGIT_W-1:0] digit_o
);

    logic [DIGIT_W-1:0] comp_w;

    // Gate-level nines complement: exact for 0..9, defined for every code
    always_comb begin
        comp_w[0] = ~digit_i[0];
        comp_w[1] =  digit_i[1];
        comp_w[2] =  digit_i[1] ^ digit_i[2];
        comp_w[3] = ~(digit_i[1] | digit_i[2] | digit_i[3]);
    end

    assign digit_o = invert_i ? comp_w : digit_i;

endmodule

// File: rtl/bcd_digit_adder.sv
module bcd_digit_adder
    import bcd_serial_pkg::*;
(
    input  logic [DIGIT_W-1:0] x_i,
    input  logic [DIGIT_W-1:0] y_i,
    input  logic               cin_i,
    output logic [DIGIT_W-1:0] sum_o,
    output logic               cout_o
);

    logic [DIGIT_W:0] raw_w;
    logic [DIGIT_W:0] adj_w;

    always_comb begin
        raw_w  = {1'b0, x_i} + {1'b0, y_i} + {{DIGIT_W{1'b0}}, cin_i};
        cout_o = (raw_w > 5'd9);
        adj_w  = raw_w + 5'd6;
        sum_o  = cout_o ? adj_w[DIGIT_W-1:0] : raw_w[DIGIT_W-1:0];
    end

endmodule

// File: rtl/bcd_seq_ctrl.sv
module bcd_seq_ctrl
    import bcd_serial_pkg::*;
#(
    parameter int DIGITS = 3
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       start_i,
    input  logic       load_i,
    output logic       accept_o,
    output logic       step_o,
    output logic       last_o,
    output logic       load_en_o,
    output logic       done_o,
    output seq_state_e state_o
);

    localparam int CNT_W = (DIGITS > 1) ? $clog2(DIGITS) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DIGITS - 1);

    seq_state_e       state_q;
    seq_state_e       state_d;
    logic [CNT_W-1:0] idx_q;
    logic             done_q;

    // next state and control strobes
    always_comb begin
        state_d   = state_q;
        accept_o  = 1'b0;
        step_o    = 1'b0;
        last_o    = (idx_q == LAST_IDX);
        load_en_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                load_en_o = load_i;
                if (start_i) begin
                    accept_o = 1'b1;
                    state_d  = ST_RUN;
                end
            end
            ST_RUN: begin
                step_o = 1'b1;
                if (last_o) begin
                    state_d = ST_IDLE;
                end
            end
        endcase
    end

    // state, digit index and done registers
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= step_o && last_o;
            if (accept_o) begin
                idx_q <= '0;
            end else if (step_o) begin
                idx_q <= idx_q + CNT_W'(1);
            end
        end
    end

    assign done_o  = done_q;
    assign state_o = state_q;

endmodule

// File: rtl/bcd_serial_addsub.sv
module bcd_serial_addsub
    import bcd_serial_pkg::*;
#(
    parameter int DIGITS = 3
) (
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic                  load_i,
    input  logic [4*DIGITS-1:0]   a_i,
    input  logic [4*DIGITS-1:0]   b_i,
    input  logic                  start_i,
    input  logic                  sub_i,
    output logic                  done_o,
    output logic [4*DIGITS-1:0]   result_o,
    output logic                  carry_o
);

    localparam int W = DIGIT_W * DIGITS;

    logic [W-1:0]       a_q, b_q, res_q;
    logic [W-1:0]       a_shift, b_shift, res_shift;
    logic               carry_q;
    logic               carry_out_q;
    logic               sub_q;
    logic [DIGIT_W-1:0] a_mod_w, sum_w;
    logic               cout_w;

    logic               accept_w, step_w, last_w, load_en_w;
    seq_state_e         state_w;

    bcd_seq_ctrl #(.DIGITS(DIGITS)) u_ctrl (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .start_i   (start_i),
        .load_i    (load_i),
        .accept_o  (accept_w),
        .step_o    (step_w),
        .last_o    (last_w),
        .load_en_o (load_en_w),
        .done_o    (done_o),
        .state_o   (state_w)
    );

    bcd_nines_comp u_comp (
        .digit_i  (a_q[DIGIT_W-1:0]),
        .invert_i (sub_q),
        .digit_o  (a_mod_w)
    );

    bcd_digit_adder u_add (
        .x_i    (a_mod_w),
        .y_i    (b_q[DIGIT_W-1:0]),
        .cin_i  (carry_q),
        .sum_o  (sum_w),
        .cout_o (cout_w)
    );

    // shift paths toward the least significant digit
    generate
        if (DIGITS > 1) begin : g_multi
            assign a_shift   = {{DIGIT_W{1'b0}}, a_q[W-1:DIGIT_W]};
            assign b_shift   = {{DIGIT_W{1'b0}}, b_q[W-1:DIGIT_W]};
            assign res_shift = {sum_w, res_q[W-1:DIGIT_W]};
        end else begin : g_single
            assign a_shift   = '0;
            assign b_shift   = '0;
            assign res_shift = sum_w;
        end
    endgenerate

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            a_q         <= '0;
            b_q         <= '0;
            res_q       <= '0;
            carry_q     <= 1'b0;
            carry_out_q <= 1'b0;
            sub_q       <= 1'b0;
        end else begin
            if (load_en_w) begin
                a_q <= a_i;
                b_q <= b_i;
            end else if (step_w) begin
                a_q <= a_shift;
                b_q <= b_shift;
            end
            if (accept_w) begin
                carry_q <= sub_i;
                sub_q   <= sub_i;
            end else if (step_w) begin
                carry_q <= cout_w;
                res_q   <= res_shift;
                if (last_w) begin
                    carry_out_q <= cout_w;
                end
            end
        end
    end

    assign result_o = res_q;
    assign carry_o  = carry_out_q;

endmodule

// File: rtl/bcd_serial_addsub_chk.sv
module bcd_serial_addsub_chk
    import bcd_serial_pkg::*;
#(
    parameter int DIGITS = 3
) (
    input logic                clk_i,
    input logic                rst_i,
    input logic                start_i,
    input logic                sub_i,
    input logic                done_o,
    input logic [4*DIGITS-1:0] result_o,
    input logic                carry_o,
    input seq_state_e          state_i,
    input logic                dig_carry_i
);

    localparam int SW = $clog2(DIGITS + 2);

    logic [SW-1:0] since_q;
    logic          running_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            since_q   <= '0;
            running_q <= 1'b0;
        end else if (state_i == ST_IDLE && start_i) begin
            since_q   <= '0;
            running_q <= 1'b1;
        end else if (running_q) begin
            since_q <= since_q + SW'(1);
            if (done_o) begin
                running_q <= 1'b0;
            end
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |=> !done_o) else $error("done longer than one cycle"); // R5

    AST_DONE_LATENCY: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> (running_q && since_q == SW'(DIGITS))) else $error("done timing"); // R7

    AST_CARRY_PRESET: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_i == ST_IDLE && start_i) |=> (dig_carry_i == $past(sub_i))) else $error("carry preset"); // R10

    AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_i == ST_IDLE) |=> ($stable(result_o) && $stable(carry_o))) else $error("idle hold"); // R6

    generate
        for (genvar g = 0; g < DIGITS; g++) begin : g_dig
            AST_RESULT_DIGIT: assert property (@(posedge clk_i) disable iff (rst_i)
                done_o |-> (result_o[4*g +: 4] <= 4'd9)) else $error("bad result digit"); // R3
        end
    endgenerate

endmodule

bind bcd_serial_addsub bcd_serial_addsub_chk #(.DIGITS(DIGITS)) u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .start_i     (start_i),
    .sub_i       (sub_i),
    .done_o      (done_o),
    .result_o    (result_o),
    .carry_o     (carry_o),
    .state_i     (state_w),
    .dig_carry_i (carry_q)
);

// File: tb/bcd_serial_addsub_tb.sv
module bcd_serial_addsub_tb;

    localparam int D = 3;
    localparam int W = 4 * D;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         load = 1'b0;
    logic         start = 1'b0;
    logic         sub = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic         done;
    logic [W-1:0] result;
    logic         carry;

    int total = 0;
    int bad = 0;
    int modv = 1;

    always #5 clk = ~clk;

    bcd_serial_addsub #(.DIGITS(D)) u_dut (
        .clk_i    (clk),
        .rst_i    (rst),
        .load_i   (load),
        .a_i      (a_in),
        .b_i      (b_in),
        .start_i  (start),
        .sub_i    (sub),
        .done_o   (done),
        .result_o (result),
        .carry_o  (carry)
    );

    function automatic logic [W-1:0] to_bcd(input int v);
        logic [W-1:0] r;
        int t;
        t = v;
        r = '0;
        for (int i = 0; i < D; i++) begin
            r[4*i +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    function automatic int from_bcd(input logic [W-1:0] r);
        int v;
        v = 0;
        for (int i = D - 1; i >= 0; i--) begin
            v = v * 10 + int'(r[4*i +: 4]);
        end
        return v;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic expect_of(input int a, input int b, input bit s,
                             output int r, output bit c);
        if (s) begin
            r = (b - a + modv) % modv;
            c = (b >= a);
        end else begin
            r = (a + b) % modv;
            c = ((a + b) >= modv);
        end
    endtask

    // called right after the negedge following the start edge
    task automatic finish_op(input int er, input bit ec, input string tag);
        for (int i = 1; i < D; i++) begin
            @(negedge clk);
            chk(done == 1'b0, {tag, " R5 early done"}, int'(done), 0);
        end
        @(negedge clk);
        chk(done == 1'b1, {tag, " R5 done"}, int'(done), 1);
        chk(from_bcd(result) == er, {tag, " result"}, from_bcd(result), er);
        chk(carry == ec, {tag, " carry"}, int'(carry), int'(ec));
        @(negedge clk);
        chk(done == 1'b0, {tag, " R5 done width"}, int'(done), 0);
        chk(from_bcd(result) == er, {tag, " R6 hold"}, from_bcd(result), er);
    endtask

    task automatic do_op(input int a, input int b, input bit s, input string tag);
        int er;
        bit ec;
        expect_of(a, b, s, er, ec);
        @(negedge clk);
        load = 1'b1; a_in = to_bcd(a); b_in = to_bcd(b);
        @(negedge clk);
        load = 1'b0; start = 1'b1; sub = s;
        @(negedge clk);
        start = 1'b0;
        finish_op(er, ec, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < D; i++) modv = modv * 10;

        // R1: reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(result == '0, "R1 result", from_bcd(result), 0);
        chk(carry == 1'b0, "R1 carry", int'(carry), 0);
        chk(done == 1'b0, "R1 done", int'(done), 0);

        // corner cases
        do_op(1, modv - 1, 1'b0, "R11 ripple");
        do_op(0, 0, 1'b0, "R3 zero");
        do_op(modv - 1, modv - 1, 1'b0, "R3 max sum");
        do_op(500, 500, 1'b1, "R10 equal");
        do_op(0, 123, 1'b1, "R10 minus zero");
        do_op(1, 0, 1'b1, "R4 borrow");
        do_op(678, 45, 1'b1, "R4 negative");
        do_op(45, 678, 1'b1, "R4 positive");

        // R2 R3 R4: broad sweep
        for (int a = 0; a < modv; a += 37) begin
            for (int b = 3; b < modv; b += 41) begin
                do_op(a, b, 1'b0, "R3 sweep");
                do_op(a, b, 1'b1, "R4 sweep");
            end
        end

        // digit-uniform exhaustive digit pairs
        for (int x = 0; x < 10; x++) begin
            for (int y = 0; y < 10; y++) begin
                do_op(x * 111, y * 111, 1'b0, "R3 digit pairs");
                do_op(x * 111, y * 111, 1'b1, "R4 digit pairs");
            end
        end

        // R7: start while busy ignored
        @(negedge clk);
        load = 1'b1; a_in = to_bcd(250); b_in = to_bcd(300);
        @(negedge clk);
        load = 1'b0; start = 1'b1; sub = 1'b0;
        @(negedge clk);
        sub = 1'b1;
        @(negedge clk);
        start = 1'b0; sub = 1'b0;
        for (int i = 2; i < D; i++) @(negedge clk);
        @(negedge clk);
        chk(done == 1'b1, "R7 done timing", int'(done), 1);
        chk(from_bcd(result) == 550, "R7 mode kept", from_bcd(result), 550);
        for (int i = 0; i < D + 2; i++) begin
            @(negedge clk);
            chk(done == 1'b0, "R7 no rerun", int'(done), 0);
        end

        // R8: load while busy ignored, operands emptied by run
        @(negedge clk);
        load = 1'b1; a_in = to_bcd(1); b_in = to_bcd(2);
        @(negedge clk);
        load = 1'b0; start = 1'b1; sub = 1'b0;
        @(negedge clk);
        start = 1'b0; load = 1'b1; a_in = to_bcd(777); b_in = to_bcd(111);
        @(negedge clk);
        load = 1'b0;
        for (int i = 2; i < D; i++) @(negedge clk);
        @(negedge clk);
        chk(from_bcd(result) == 3, "R8 first run", from_bcd(result), 3);
        @(negedge clk);
        start = 1'b1; sub = 1'b0;
        @(negedge clk);
        start = 1'b0;
        finish_op(0, 1'b0, "R8 busy load ignored");

        // R6: idle activity does not disturb outputs
        do_op(999, 998, 1'b0, "R6 setup");
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            load = i[0]; sub = ~i[0]; a_in = to_bcd(i * 100); b_in = to_bcd(5);
            chk(from_bcd(result) == 997 && carry == 1'b1, "R6 idle hold", from_bcd(result), 997);
        end
        load = 1'b0;

        // R9: reset during run
        do_op(0, 0, 1'b0, "R9 clear");
        @(negedge clk);
        load = 1'b1; a_in = to_bcd(999); b_in = to_bcd(999);
        @(negedge clk);
        load = 1'b0; start = 1'b1; sub = 1'b0;
        @(negedge clk);
        start = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(result == '0, "R9 result cleared", from_bcd(result), 0);
        chk(carry == 1'b0, "R9 carry cleared", int'(carry), 0);
        for (int i = 0; i < D + 2; i++) begin
            @(negedge clk);
            chk(done == 1'b0, "R9 no done", int'(done), 0);
        end
        do_op(12, 34, 1'b0, "R9 after reset");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule